// File: doc/BRIEF.md
# Serial Memory Sector-Erase Command Controller

This block is the slave-side command decoder of a serial memory device with a four-wire SPI port. It oversamples the chip-select, serial-clock and serial-input pins with the system clock, shifts command bits in on rising serial-clock edges while chip select is low, and acts on three opcodes: write-enable (`8'h06`), read-status (`8'h05`) and sector-erase (`8'hD8`, followed by a 24-bit address sent MSB first). Everything else is ignored until chip select returns high.

An erase is accepted only when chip select rises immediately after the 32nd bit of the frame, the write-enable latch was set by an earlier write-enable command, the device is idle, and the addressed sector is not covered by the two block-protect inputs. Once accepted, the erase sequencer raises a request to the memory array, waits for the array's done pulse, and then stays busy for a parameterised number of system clocks. The write-in-progress flag in the status byte is 1 from the acceptance until the end of that interval. The array has four 32 KB sectors chosen by address bits 16:15.

The command state machine has eight states. IDLE goes to OPCODE when chip select falls. After eight bits, OPCODE goes to WREN, STATUS, ADDR or SKIP according to the opcode; while busy, every opcode except read-status goes to SKIP. WREN returns to IDLE on a chip-select rise (setting the latch) and goes to SKIP on any further clock. ADDR goes to ADDR_FULL at bit 32. From ADDR_FULL, a chip-select rise starts or aborts the erase and a further clock goes to ADDR_BAD. ADDR and ADDR_BAD abort on a chip-select rise. STATUS and SKIP return to IDLE when chip select rises. The erase sequencer moves ER_IDLE to ER_REQ on start, ER_REQ to ER_HOLD on the array's done pulse, and ER_HOLD to ER_IDLE when the hold count expires.

Top module: `spi_sector_erase_ctl`

## Requirements
- R1: After reset the status byte reads 8'h00, `spi_so_oe` is 0 and `erase_req` is 0.
- R2: A write-enable opcode 8'h06 of exactly eight bits followed by a chip-select rise sets the write-enable latch (status bit 1). If a ninth clock arrives before chip select rises, the latch is not set.
- R3: After read-status opcode 8'h05, `spi_so` carries the status byte MSB first, with bit 1 the write-enable latch and bit 0 write-in-progress. Each bit changes on a falling serial clock, starting with the fall after the eighth opcode bit. The byte repeats for as long as clocks continue, and `spi_so_oe` is 1 only during this phase.
- R4: Opcode 8'hD8 plus 24 address bits, MSB first, with chip select rising right after bit 32, the latch set and the sector unprotected, raises `erase_req` with `erase_sector` = address[16:15]. That sector then reads 8'hFF and the other sectors are unchanged.
- R5: If chip select rises after fewer or more than 32 bits of an erase frame, no erase is requested.
- R6: An erase frame sent while the write-enable latch is clear requests no erase.
- R7: Block-protect value 00 protects nothing, 01 protects sector 3, 10 protects sectors 2 and 3, and 11 protects all sectors. An erase to a protected sector requests nothing.
- R8: Write-in-progress is 1 from the accepting chip-select rise until ERASE_CYCLES clocks after the array's done pulse. `erase_req` is high only while it is 1.
- R9: The write-enable latch is cleared when an erase completes and when an erase frame ends without starting an erase.
- R10: While write-in-progress is 1, every opcode other than read-status is ignored, including a complete, well-formed erase frame.
- R11: `spi_so_oe` stays 0 throughout an erase frame.
- R12: Address bits outside 16:15 do not affect which sector is erased.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Drive enable for `spi_so`; 0 means high impedance |
| bp_level | input | 2 | Block-protect setting |
| erase_req | output | 1 | Erase request to the array, held until done |
| erase_sector | output | SECT_BITS | Sector being erased |
| erase_done | input | 1 | One-cycle pulse from the array when the sector is cleared |

## Verification
The assertions assume three things about the inputs. The array pulses `erase_done` only while `erase_req` is high. `bp_level` does not change in the cycle an erase is accepted. Serial-clock and chip-select transitions are at least a few system clocks apart, so the synchroniser sees them in order. The bench keeps to these rules: it changes pins only on falling system-clock edges, uses six-clock half periods on the serial clock, waits between the last clock fall and the chip-select rise, alters `bp_level` only between commands, and answers each request with a single done pulse a few cycles later.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_OPCODE,
        CMD_WREN,
        CMD_STATUS,
        CMD_ADDR,
        CMD_ADDR_FULL,
        CMD_ADDR_BAD,
        CMD_SKIP
    } cmd_state_t;

    typedef enum logic [1:0] {
        ER_IDLE,
        ER_REQ,
        ER_HOLD
    } er_state_t;

    localparam logic [7:0] OPC_WRITE_EN   = 8'h06;
    localparam logic [7:0] OPC_READ_STAT  = 8'h05;
    localparam logic [7:0] OPC_SECT_ERASE = 8'hD8;

    // Quarter / half / all protection against the top of the sector range.
    function automatic logic sector_locked(input logic [1:0] bp,
                                           input int unsigned sect,
                                           input int unsigned nsect);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return sect >= nsect - nsect / 4;
            2'b10:   return sect >= nsect / 2;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            dout   <= RST_VAL;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/spi_shift_in.sv
module spi_shift_in #(
    parameter int WIDTH     = 17,
    parameter int CNT_W     = 6,
    parameter int PEEK_W    = 7,
    parameter int FIELD_LSB = 15,
    parameter int FIELD_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               shift_en,
    input  logic               din,
    output logic [PEEK_W-1:0]  peek,
    output logic [FIELD_W-1:0] field,
    output logic [CNT_W-1:0]   bit_cnt
);
    logic [WIDTH-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            bit_cnt <= '0;
        end else begin
            if (shift_en)
                sh_q <= {sh_q[WIDTH-2:0], din};
            if (clear)
                bit_cnt <= '0;
            else if (shift_en && bit_cnt != '1)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign peek  = sh_q[PEEK_W-1:0];
    assign field = sh_q[FIELD_LSB +: FIELD_W];
endmodule

// File: rtl/erase_sequencer.sv
module erase_sequencer
    import spi_erase_pkg::*;
#(
    parameter int ERASE_CYCLES = 1000,
    parameter int SECT_BITS    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [SECT_BITS-1:0] start_sector,
    input  logic                 erase_done,
    output logic                 erase_req,
    output logic [SECT_BITS-1:0] erase_sector,
    output logic                 wip,
    output logic                 finish
);
    localparam int               CNT_W = $clog2(ERASE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(ERASE_CYCLES - 1);

    er_state_t            state, nxt;
    logic [CNT_W-1:0]     hold_cnt;
    logic [SECT_BITS-1:0] sect_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ER_IDLE;
            hold_cnt <= '0;
            sect_q   <= '0;
        end else begin
            state <= nxt;
            if (state != ER_HOLD)
                hold_cnt <= '0;
            else
                hold_cnt <= hold_cnt + 1'b1;
            if (start && state == ER_IDLE)
                sect_q <= start_sector;
        end
    end

    always_comb begin
        nxt    = state;
        finish = 1'b0;
        unique case (state)
            ER_IDLE: if (start)      nxt = ER_REQ;
            ER_REQ:  if (erase_done) nxt = ER_HOLD;
            ER_HOLD: if (hold_cnt == LAST) begin
                nxt    = ER_IDLE;
                finish = 1'b1;
            end
            default: nxt = ER_IDLE;
        endcase
    end

    assign erase_req    = (state == ER_REQ);
    assign wip          = (state != ER_IDLE);
    assign erase_sector = sect_q;
endmodule

// File: rtl/spi_sector_erase_ctl.sv
module spi_sector_erase_ctl
    import spi_erase_pkg::*;
#(
    parameter int ADDR_BITS    = 24,
    parameter int SECT_BITS    = 2,
    parameter int SECT_LSB     = 15,
    parameter int ERASE_CYCLES = 1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_cs_n,
    input  logic                 spi_sck,
    input  logic                 spi_si,
    output logic                 spi_so,
    output logic                 spi_so_oe,
    input  logic [1:0]           bp_level,
    output logic                 erase_req,
    output logic [SECT_BITS-1:0] erase_sector,
    input  logic                 erase_done
);
    localparam int OP_BITS    = 8;
    localparam int FRAME_BITS = OP_BITS + ADDR_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam int SECT_TOP   = SECT_LSB + SECT_BITS;
    localparam int PEEK_W     = OP_BITS - 1;
    localparam int SH_W       = (SECT_TOP > PEEK_W) ? SECT_TOP : PEEK_W;
    localparam int NUM_SECT   = 1 << SECT_BITS;

    // ---------------- pin sampling and edge events ----------------
    logic [2:0] pins_sync;
    logic       sck_lvl, cs_lvl, si_lvl, sck_prev, cs_prev;
    logic       sck_rise, sck_fall, cs_rise_evt, cs_fall_evt;

    spi_pin_sync #(.WIDTH(3), .RST_VAL(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_si, spi_cs_n, spi_sck}),
        .dout (pins_sync)
    );

    assign sck_lvl = pins_sync[0];
    assign cs_lvl  = pins_sync[1];
    assign si_lvl  = pins_sync[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_prev <= sck_lvl;
            cs_prev  <= cs_lvl;
        end
    end

    assign sck_rise    = sck_lvl & ~sck_prev & ~cs_lvl;
    assign sck_fall    = ~sck_lvl & sck_prev;
    assign cs_rise_evt = cs_lvl & ~cs_prev;
    assign cs_fall_evt = ~cs_lvl & cs_prev;

    // ---------------- input shifter ----------------
    logic [PEEK_W-1:0]    op_head;
    logic [SECT_BITS-1:0] addr_sect;
    logic [CNT_W-1:0]     bit_cnt;
    logic [7:0]           op_now;

    spi_shift_in #(
        .WIDTH(SH_W), .CNT_W(CNT_W), .PEEK_W(PEEK_W),
        .FIELD_LSB(SECT_LSB), .FIELD_W(SECT_BITS)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cs_lvl),
        .shift_en(sck_rise),
        .din     (si_lvl),
        .peek    (op_head),
        .field   (addr_sect),
        .bit_cnt (bit_cnt)
    );

    assign op_now = {op_head, si_lvl};

    // ---------------- erase sequencer ----------------
    logic wip, er_start, er_finish;

    erase_sequencer #(.ERASE_CYCLES(ERASE_CYCLES), .SECT_BITS(SECT_BITS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (er_start),
        .start_sector(addr_sect),
        .erase_done  (erase_done),
        .erase_req   (erase_req),
        .erase_sector(erase_sector),
        .wip         (wip),
        .finish      (er_finish)
    );

    // ---------------- command state machine ----------------
    cmd_state_t state, nxt;
    logic       wel_q, wel_set, er_abort, locked;

    assign locked = sector_locked(bp_level, 32'(addr_sect), NUM_SECT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CMD_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt      = state;
        wel_set  = 1'b0;
        er_start = 1'b0;
        er_abort = 1'b0;
        unique case (state)
            CMD_IDLE: if (cs_fall_evt) nxt = CMD_OPCODE;
            CMD_OPCODE: begin
                if (cs_rise_evt)
                    nxt = CMD_IDLE;
                else if (sck_rise && bit_cnt == CNT_W'(OP_BITS - 1)) begin
                    if (wip && op_now != OPC_READ_STAT)
                        nxt = CMD_SKIP;
                    else begin
                        case (op_now)
                            OPC_WRITE_EN:   nxt = CMD_WREN;
                            OPC_READ_STAT:  nxt = CMD_STATUS;
                            OPC_SECT_ERASE: nxt = CMD_ADDR;
                            default:        nxt = CMD_SKIP;
                        endcase
                    end
                end
            end
            CMD_WREN: begin
                if (cs_rise_evt) begin
                    wel_set = 1'b1;
                    nxt     = CMD_IDLE;
                end else if (sck_rise)
                    nxt = CMD_SKIP;
            end
            CMD_STATUS: if (cs_rise_evt) nxt = CMD_IDLE;
            CMD_ADDR: begin
                if (cs_rise_evt) begin
                    er_abort = 1'b1;
                    nxt      = CMD_IDLE;
                end else if (sck_rise && bit_cnt == CNT_W'(FRAME_BITS - 1))
                    nxt = CMD_ADDR_FULL;
            end
            CMD_ADDR_FULL: begin
                if (cs_rise_evt) begin
                    if (wel_q && !locked) er_start = 1'b1;
                    else                  er_abort = 1'b1;
                    nxt = CMD_IDLE;
                end else if (sck_rise)
                    nxt = CMD_ADDR_BAD;
            end
            CMD_ADDR_BAD: begin
                if (cs_rise_evt) begin
                    er_abort = 1'b1;
                    nxt      = CMD_IDLE;
                end
            end
            CMD_SKIP: if (cs_rise_evt) nxt = CMD_IDLE;
            default:  nxt = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     wel_q <= 1'b0;
        else if (er_finish || er_abort) wel_q <= 1'b0;
        else if (wel_set)               wel_q <= 1'b1;
    end

    // ---------------- status output ----------------
    logic [7:0] status_byte;
    logic [2:0] out_idx;
    logic       so_bit;

    assign status_byte = {6'b0, wel_q, wip};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_idx <= 3'd7;
            so_bit  <= 1'b0;
        end else if (state != CMD_STATUS) begin
            out_idx <= 3'd7;
        end else if (sck_fall) begin
            so_bit  <= status_byte[out_idx];
            out_idx <= out_idx - 3'd1;
        end
    end

    assign spi_so    = so_bit;
    assign spi_so_oe = (state == CMD_STATUS);
endmodule

// File: rtl/spi_erase_checker.sv
module spi_erase_checker
    import spi_erase_pkg::*;
#(
    parameter int SECT_BITS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 erase_req,
    input logic                 erase_done,
    input logic [SECT_BITS-1:0] erase_sector,
    input logic [1:0]           bp_level,
    input logic                 wip,
    input logic                 wel_q,
    input logic                 cs_rise_evt
);
    localparam int NUM_SECT = 1 << SECT_BITS;

    assert_req_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_req) |-> wel_q);

    assert_sector_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && $past(erase_req)) |-> $stable(erase_sector));

    assert_req_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_req) |-> !sector_locked(bp_level, 32'(erase_sector), NUM_SECT));

    assert_req_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> wip);

    assert_done_in_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |-> erase_req);

    assert_wel_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel_q);

    assert_wel_on_cs_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> $past(cs_rise_evt));
endmodule

bind spi_sector_erase_ctl spi_erase_checker #(.SECT_BITS(SECT_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .erase_req   (erase_req),
    .erase_done  (erase_done),
    .erase_sector(erase_sector),
    .bp_level    (bp_level),
    .wip         (wip),
    .wel_q       (wel_q),
    .cs_rise_evt (cs_rise_evt)
);

// File: tb/spi_sector_erase_ctl_tb.sv
module spi_sector_erase_ctl_tb;
    localparam int HALF      = 6;
    localparam int ERASE_CYC = 1500;
    localparam int NVEC      = 11;
    // {wren[29], bp[28:27], timing[26:25] 0=exact 1=short 2=long, expect[24], addr[23:0]}
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 2'd0, 1'b1, 24'h012345},
        {1'b1, 2'd1, 2'd0, 1'b0, 24'h01FFFF},
        {1'b1, 2'd1, 2'd0, 1'b1, 24'h010000},
        {1'b1, 2'd2, 2'd0, 1'b0, 24'h010000},
        {1'b1, 2'd2, 2'd0, 1'b1, 24'h00FFFF},
        {1'b1, 2'd3, 2'd0, 1'b0, 24'h000000},
        {1'b0, 2'd0, 2'd0, 1'b0, 24'h000100},
        {1'b1, 2'd0, 2'd1, 1'b0, 24'h008000},
        {1'b1, 2'd0, 2'd2, 1'b0, 24'h008000},
        {1'b1, 2'd0, 2'd0, 1'b1, 24'h007FFF},
        {1'b1, 2'd0, 2'd0, 1'b1, 24'hFE8000}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1, spi_sck = 1'b0, spi_si = 1'b0;
    logic       spi_so, spi_so_oe;
    logic [1:0] bp_level = 2'd0;
    logic       erase_req;
    logic [1:0] erase_sector;
    logic       erase_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spi_sector_erase_ctl #(.ERASE_CYCLES(ERASE_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_si(spi_si), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
        .bp_level(bp_level), .erase_req(erase_req),
        .erase_sector(erase_sector), .erase_done(erase_done)
    );

    // Behavioural array: one fill byte per sector.
    logic [7:0] fill [4];
    logic       fill_reset = 1'b0;
    logic       req_d;
    int         req_count;
    int         dly;

    always @(posedge clk) begin
        if (!rst_n) begin
            erase_done <= 1'b0;
            req_d      <= 1'b0;
            req_count  <= 0;
            dly        <= 0;
            for (int k = 0; k < 4; k++) fill[k] <= 8'h5A;
        end else begin
            erase_done <= 1'b0;
            req_d      <= erase_req;
            if (erase_req && !req_d) req_count <= req_count + 1;
            if (fill_reset)
                for (int k = 0; k < 4; k++) fill[k] <= 8'h5A;
            if (erase_req && !erase_done) begin
                if (dly == 3) begin
                    fill[erase_sector] <= 8'hFF;
                    erase_done         <= 1'b1;
                    dly                <= 0;
                end else dly <= dly + 1;
            end else dly <= 0;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_x(input logic b, output logic so_v, output logic oe_v);
        spi_si = b;
        wait_clk(HALF);
        so_v = spi_so;
        oe_v = spi_so_oe;
        spi_sck = 1'b1;
        wait_clk(HALF);
        spi_sck = 1'b0;
    endtask

    task automatic cs_lo();
        spi_cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_hi();
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic d, o;
        for (int i = 7; i >= 0; i--) bit_x(v[i], d, o);
    endtask

    task automatic send_wren(input int extra);
        logic d, o;
        cs_lo();
        send_byte(8'h06);
        for (int i = 0; i < extra; i++) bit_x(1'b0, d, o);
        cs_hi();
    endtask

    task automatic read_status(input int nbytes, output logic [7:0] first,
                               output logic [7:0] last, output int oe_bad);
        logic b, o;
        logic [7:0] s;
        oe_bad = 0;
        first  = 8'h00;
        s      = 8'h00;
        cs_lo();
        send_byte(8'h05);
        for (int n = 0; n < nbytes; n++) begin
            for (int i = 0; i < 8; i++) begin
                bit_x(1'b0, b, o);
                s = {s[6:0], b};
                if (o !== 1'b1) oe_bad++;
            end
            if (n == 0) first = s;
        end
        last = s;
        cs_hi();
    endtask

    task automatic send_erase(input logic [23:0] a, input int nbits, output int oe_seen);
        logic d, o;
        oe_seen = 0;
        cs_lo();
        for (int i = 7; i >= 0; i--) begin
            bit_x(((8'hD8 >> i) & 8'h01) != 0, d, o);
            if (o !== 1'b0) oe_seen++;
        end
        for (int k = 0; k < nbits - 8; k++) begin
            bit_x((k < 24) ? a[23-k] : 1'b0, d, o);
            if (o !== 1'b0) oe_seen++;
        end
        cs_hi();
    endtask

    task automatic wait_idle(output logic [7:0] s);
        logic [7:0] f;
        int ob;
        s = 8'hEE;
        for (int p = 0; p < 20; p++) begin
            read_status(1, f, s, ob);
            if (s[0] == 1'b0) break;
        end
    endtask

    task automatic pulse_fill_reset();
        fill_reset = 1'b1;
        wait_clk(1);
        fill_reset = 1'b0;
        wait_clk(1);
    endtask

    initial begin
        logic [7:0] s1, s2;
        int ob, base;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1: reset state
        check("R1 so_oe after reset", 32'(spi_so_oe), 0);
        check("R1 erase_req after reset", 32'(erase_req), 0);
        read_status(1, s1, s2, ob);
        check("R1 status after reset", 32'(s2), 32'h00);
        check("R3 so_oe during status read", 32'(ob), 0);
        check("R3 so_oe after status read", 32'(spi_so_oe), 0);

        // R2: write enable with a ninth clock is rejected
        send_wren(1);
        read_status(1, s1, s2, ob);
        check("R2 wren with 9 clocks", 32'(s2), 32'h00);

        // R2/R3: proper write enable, status byte repeated
        send_wren(0);
        read_status(2, s1, s2, ob);
        check("R2 wren sets latch", 32'(s1), 32'h02);
        check("R3 status byte repeats", 32'(s2), 32'h02);
        check("R3 so_oe over two bytes", 32'(ob), 0);

        // R9: short erase frame aborts and clears the latch
        send_erase(24'h000000, 20, ob);
        read_status(1, s1, s2, ob);
        check("R9 abort clears latch", 32'(s2), 32'h00);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [29:0] v;
            logic [23:0] a;
            logic [1:0]  sect;
            int nbits, oe_seen;
            string tag;
            v     = VEC[i];
            a     = v[23:0];
            sect  = a[16:15];
            nbits = (v[26:25] == 2'd1) ? 31 : (v[26:25] == 2'd2) ? 33 : 32;
            if (v[24]) tag = (v[28:27] != 2'd0) ? "R7" : (a[23:17] != 0) ? "R12" : "R4";
            else       tag = (v[26:25] != 2'd0) ? "R5" : (!v[29]) ? "R6" : "R7";
            pulse_fill_reset();
            bp_level = v[28:27];
            base     = req_count;
            if (v[29]) send_wren(0);
            send_erase(a, nbits, oe_seen);
            check("R11 so_oe during erase frame", 32'(oe_seen), 0);
            read_status(1, s1, s2, ob);
            if (v[24]) begin
                check({"R8 busy status ", tag}, 32'(s2), 32'h03);
                wait_idle(s2);
                check("R9 status after erase", 32'(s2), 32'h00);
                check({tag, " request count"}, 32'(req_count - base), 1);
                for (int k = 0; k < 4; k++)
                    check({tag, " sector fill"}, 32'(fill[k]),
                          (k == 32'(sect)) ? 32'hFF : 32'h5A);
            end else begin
                check({"R9 ", tag, " status after rejected frame"}, 32'(s2), 32'h00);
                check({tag, " no request"}, 32'(req_count - base), 0);
                for (int k = 0; k < 4; k++)
                    check({tag, " fill unchanged"}, 32'(fill[k]), 32'h5A);
            end
        end

        // R10: erase frame sent while busy is ignored
        pulse_fill_reset();
        bp_level = 2'd0;
        base     = req_count;
        send_wren(0);
        send_erase(24'h000000, 32, ob);
        send_erase(24'h018000, 32, ob);
        read_status(1, s1, s2, ob);
        check("R10 still busy after ignored frame", 32'(s2[0]), 1);
        wait_idle(s2);
        check("R10 single request", 32'(req_count - base), 1);
        check("R10 sector 3 untouched", 32'(fill[3]), 32'h5A);
        check("R10 sector 0 erased", 32'(fill[0]), 32'hFF);
        check("R9 latch clear after busy", 32'(s2), 32'h00);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule